// File: doc/BRIEF.md
# Two-Term Redundant-Ring Multiplier

This block multiplies two elements of a 16-bit ring whose elements are linear polynomials in `y`. Each coefficient is a byte of the binary extension field of order 256, and products are reduced modulo a quadratic `y^2 + c1*y + c0`. The two quadratic coefficients are themselves field bytes. They are supplied on input ports, so one instance can serve any modulus built from two distinct field roots, with `c1 = a1 + a2` and `c0 = a1*a2`. Either operand may be held constant, for example an idempotent, and the other one streamed.

A caller presents two operands and a modulus and raises `start` for one cycle. The block accepts a start on every cycle. After a fixed latency it raises `done` for one cycle and updates `product`. Each ring product needs six field multiplications and three field additions. Every field multiplication is an eight-step shift-and-conditional-XOR network, so no lookup tables are used. A parameter can insert one register stage between the first and second layers of field multipliers.

Top module: `ring_mul_top`

## Requirements
- R1: While reset is asserted and after it is released, `done` is 0 and `product` is 0 until the first start is accepted.
- R2: With `PIPE_STAGES` = 0, a start sampled at a rising edge makes `done` 1 during the next clock cycle only. Each added pipeline stage adds one cycle. When no start was accepted, `done` stays 0.
- R3: Operand bits [15:8] hold the coefficient of `y` and bits [7:0] hold the constant coefficient. `product` is the full polynomial product reduced with `y^2 = c1*y + c0`, with the same bit layout.
- R4: Coefficient arithmetic is carry-less multiplication modulo x^8+x^4+x^3+x+1 (0x11B). For example, 0x0057 times 0x0083 gives 0x00C1.
- R5: `modC1` and `modC0` are taken in the same cycle as the operands, so consecutive starts may use different moduli.
- R6: While no result is being delivered, `product` holds its last value, whatever happens on the operand and modulus inputs.
- R7: A zero operand gives a zero product.
- R8: An operand of 0x0001 is the multiplicative identity: the product equals the other operand.
- R9: y times y (0x0100 times 0x0100) gives {c1, c0}.
- R10: Starts on consecutive cycles each yield their own result, in order, one per cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Accept the operands and modulus present this cycle |
| aOp | input | 2*FIELD_W | First operand, {y coefficient, constant} |
| bOp | input | 2*FIELD_W | Second operand, same layout |
| modC1 | input | FIELD_W | Modulus coefficient of y |
| modC0 | input | FIELD_W | Modulus constant term |
| done | output | 1 | One-cycle pulse when `product` is updated |
| product | output | 2*FIELD_W | Reduced ring product |

## Verification
The hardest situation to reach is a fully loaded stream: starts on every cycle, with a different modulus each time, so that a result could be paired with the wrong operands or the wrong modulus. The bench drives long gap-free bursts of random operands. For each start it derives a fresh modulus from two random distinct roots. A queue pairs every result with the start that produced it. Directed cases cover the fixed points of the reduction: y squared, zero, the identity, and a known field product.

// File: rtl/ring_mul_pkg.sv
package ring_mul_pkg;

  // Strobes from the sequencer to the arithmetic path
  typedef struct packed {
    logic capIn;   // operands valid this cycle
    logic capOut;  // result register loads this cycle
  } ringCtrl_t;

endpackage

// File: rtl/gf_mul.sv
// Carry-less field multiply with interleaved reduction, LSB first.
module gf_mul #(
  parameter int unsigned W = 8,
  parameter logic [W-1:0] POLY = 8'h1B
) (
  input  logic [W-1:0] opX,
  input  logic [W-1:0] opY,
  output logic [W-1:0] prod
);

  logic [W-1:0] accum [W+1];
  logic [W-1:0] shifted [W+1];

  assign accum[0]   = '0;
  assign shifted[0] = opX;

  for (genvar i = 0; i < W; i++) begin : g_step
    assign accum[i+1]   = accum[i] ^ (opY[i] ? shifted[i] : '0);
    assign shifted[i+1] = {shifted[i][W-2:0], 1'b0} ^ (shifted[i][W-1] ? POLY : '0);
  end

  assign prod = accum[W];

endmodule

// File: rtl/ring_mul_ctrl.sv
module ring_mul_ctrl
  import ring_mul_pkg::*;
#(
  parameter int unsigned PIPE_STAGES = 0
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  output ringCtrl_t ctrl,
  output logic      done
);

  assign ctrl.capIn = start;

  if (PIPE_STAGES == 0) begin : g_direct
    assign ctrl.capOut = start;

    assert_done_after_start_R2: assert property (@(posedge clk) disable iff (!rstN)
      start |=> done);
    assert_no_stray_done_R2: assert property (@(posedge clk) disable iff (!rstN)
      !start |=> !done);
  end else begin : g_staged
    logic validQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) validQ <= 1'b0;
      else       validQ <= start;
    end
    assign ctrl.capOut = validQ;

    assert_done_after_start_R2: assert property (@(posedge clk) disable iff (!rstN)
      start |=> ##1 done);
    assert_no_stray_done_R2: assert property (@(posedge clk) disable iff (!rstN)
      !start |=> ##1 !done);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) done <= 1'b0;
    else       done <= ctrl.capOut;
  end

endmodule

// File: rtl/ring_mul_dp.sv
module ring_mul_dp
  import ring_mul_pkg::*;
#(
  parameter int unsigned FIELD_W = 8,
  parameter logic [FIELD_W-1:0] FIELD_POLY = 8'h1B,
  parameter int unsigned PIPE_STAGES = 0,
  localparam int unsigned RING_W = 2 * FIELD_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  ringCtrl_t         ctrl,
  input  logic [RING_W-1:0] aOp,
  input  logic [RING_W-1:0] bOp,
  input  logic [FIELD_W-1:0] modC1,
  input  logic [FIELD_W-1:0] modC0,
  output logic [RING_W-1:0] product
);

  localparam int unsigned NUM_FIRST = 4;
  localparam logic [RING_W-1:0] RING_ONE = RING_W'(1);

  logic [FIELD_W-1:0] aHi, aLo, bHi, bLo;
  assign aHi = aOp[RING_W-1:FIELD_W];
  assign aLo = aOp[FIELD_W-1:0];
  assign bHi = bOp[RING_W-1:FIELD_W];
  assign bLo = bOp[FIELD_W-1:0];

  // First layer: 0 = hi*hi, 1 = hi*lo, 2 = lo*hi, 3 = lo*lo
  logic [FIELD_W-1:0] firstX [NUM_FIRST];
  logic [FIELD_W-1:0] firstY [NUM_FIRST];
  logic [FIELD_W-1:0] firstP [NUM_FIRST];

  assign firstX[0] = aHi;  assign firstY[0] = bHi;
  assign firstX[1] = aHi;  assign firstY[1] = bLo;
  assign firstX[2] = aLo;  assign firstY[2] = bHi;
  assign firstX[3] = aLo;  assign firstY[3] = bLo;

  for (genvar k = 0; k < NUM_FIRST; k++) begin : g_first
    gf_mul #(.W(FIELD_W), .POLY(FIELD_POLY)) u_mul (
      .opX(firstX[k]), .opY(firstY[k]), .prod(firstP[k])
    );
  end

  // Optional stage between the layers
  logic [FIELD_W-1:0] midP [NUM_FIRST];
  logic [FIELD_W-1:0] midC1, midC0;

  if (PIPE_STAGES == 0) begin : g_comb
    for (genvar k = 0; k < NUM_FIRST; k++) begin : g_pass
      assign midP[k] = firstP[k];
    end
    assign midC1 = modC1;
    assign midC0 = modC0;
  end else begin : g_reg
    for (genvar k = 0; k < NUM_FIRST; k++) begin : g_stage
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)           midP[k] <= '0;
        else if (ctrl.capIn) midP[k] <= firstP[k];
      end
    end
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        midC1 <= '0;
        midC0 <= '0;
      end else if (ctrl.capIn) begin
        midC1 <= modC1;
        midC0 <= modC0;
      end
    end
  end

  // Second layer: fold the y^2 term back with the modulus
  logic [FIELD_W-1:0] foldHi, foldLo;
  gf_mul #(.W(FIELD_W), .POLY(FIELD_POLY)) u_foldHi (
    .opX(midP[0]), .opY(midC1), .prod(foldHi)
  );
  gf_mul #(.W(FIELD_W), .POLY(FIELD_POLY)) u_foldLo (
    .opX(midP[0]), .opY(midC0), .prod(foldLo)
  );

  logic [FIELD_W-1:0] sumHi, sumLo;
  assign sumHi = midP[1] ^ midP[2] ^ foldHi;
  assign sumLo = midP[3] ^ foldLo;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            product <= '0;
    else if (ctrl.capOut) product <= {sumHi, sumLo};
  end

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.capOut |=> $stable(product));

  if (PIPE_STAGES == 0) begin : g_chk
    assert_zero_operand_R7: assert property (@(posedge clk) disable iff (!rstN)
      ctrl.capIn && (aOp == '0) |=> (product == '0));
    assert_identity_R8: assert property (@(posedge clk) disable iff (!rstN)
      ctrl.capIn && (bOp == RING_ONE) |=> (product == $past(aOp)));
  end else begin : g_chk
    assert_zero_operand_R7: assert property (@(posedge clk) disable iff (!rstN)
      ctrl.capIn && (aOp == '0) |=> ##1 (product == '0));
  end

endmodule

// File: rtl/ring_mul_top.sv
module ring_mul_top
  import ring_mul_pkg::*;
#(
  parameter int unsigned FIELD_W = 8,
  parameter logic [FIELD_W-1:0] FIELD_POLY = 8'h1B,
  parameter int unsigned PIPE_STAGES = 0
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   start,
  input  logic [2*FIELD_W-1:0]   aOp,
  input  logic [2*FIELD_W-1:0]   bOp,
  input  logic [FIELD_W-1:0]     modC1,
  input  logic [FIELD_W-1:0]     modC0,
  output logic                   done,
  output logic [2*FIELD_W-1:0]   product
);

  ringCtrl_t ctrl;

  ring_mul_ctrl #(.PIPE_STAGES(PIPE_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .ctrl(ctrl), .done(done)
  );

  ring_mul_dp #(
    .FIELD_W(FIELD_W), .FIELD_POLY(FIELD_POLY), .PIPE_STAGES(PIPE_STAGES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl),
    .aOp(aOp), .bOp(bOp), .modC1(modC1), .modC0(modC0),
    .product(product)
  );

endmodule

// File: tb/sim_ring_mul_top.sv
module sim_ring_mul_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [15:0] aOp = '0;
  logic [15:0] bOp = '0;
  logic [7:0]  modC1 = '0;
  logic [7:0]  modC0 = '0;
  logic        done;
  logic [15:0] product;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [15:0] expQ [$];
  string       tagQ [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  ring_mul_top u0 (
    .clk(clk), .rstN(rstN), .start(start), .aOp(aOp), .bOp(bOp),
    .modC1(modC1), .modC0(modC0), .done(done), .product(product)
  );

  // Reference: full carry-less product, then reduce from the top bit down
  function automatic logic [7:0] fieldMul(input logic [7:0] x, input logic [7:0] y);
    logic [15:0] wide = '0;
    for (int i = 0; i < 8; i++) if (y[i]) wide ^= 16'(x) << i;
    for (int i = 14; i >= 8; i--) if (wide[i]) wide ^= 16'h011B << (i - 8);
    return wide[7:0];
  endfunction

  function automatic logic [15:0] ringMul(input logic [15:0] a, input logic [15:0] b,
                                          input logic [7:0] c1, input logic [7:0] c0);
    logic [7:0] sq, mid, low;
    sq  = fieldMul(a[15:8], b[15:8]);
    mid = fieldMul(a[15:8], b[7:0]) ^ fieldMul(a[7:0], b[15:8]);
    low = fieldMul(a[7:0], b[7:0]);
    return {mid ^ fieldMul(sq, c1), low ^ fieldMul(sq, c0)};
  endfunction

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // Driver: present one start, push its expected result
  task automatic issue(input logic [15:0] a, input logic [15:0] b,
                       input logic [7:0] c1, input logic [7:0] c0, input string tag);
    aOp = a; bOp = b; modC1 = c1; modC0 = c0; start = 1'b1;
    expQ.push_back(ringMul(a, b, c1, c0));
    tagQ.push_back(tag);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    start = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // Monitor: pop and compare as results appear
  always @(negedge clk) begin
    if (rstN && done) begin
      if (expQ.size() == 0) begin
        check("R2 unexpected done", 16'(done), 16'h0);
      end else begin
        logic [15:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(t, product, e);
      end
    end
  end

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      report();
    end
  end

  initial begin
    logic [15:0] held;
    logic [7:0]  r1, r2;

    repeat (3) @(negedge clk);
    check("R1 done in reset", 16'(done), 16'h0);
    check("R1 product in reset", product, 16'h0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 done after reset", 16'(done), 16'h0);
    check("R1 product after reset", product, 16'h0);

    // R2: single pulse, one cycle after acceptance
    issue(16'h1234, 16'h5678, 8'h03, 8'h02, "R2 single product");
    start = 1'b0;
    check("R2 done high", 16'(done), 16'h1);
    @(negedge clk);
    check("R2 done one cycle only", 16'(done), 16'h0);

    // R4: known field product in the constant coefficient
    issue(16'h0057, 16'h0083, 8'h00, 8'h00, "R4 field product");
    idle(1);
    check("R4 literal 57*83", ringMul(16'h0057, 16'h0083, 8'h0, 8'h0), 16'h00C1);

    // R9: y*y folds to the modulus
    issue(16'h0100, 16'h0100, 8'h12, 8'h34, "R9 y squared");
    idle(1);
    check("R9 literal", product, 16'h1234);

    // R7 and R8
    issue(16'h0000, 16'hBEEF, 8'h5A, 8'hC3, "R7 zero operand");
    issue(16'hBEEF, 16'h0000, 8'h5A, 8'hC3, "R7 zero operand b");
    issue(16'hA5C3, 16'h0001, 8'h77, 8'h19, "R8 identity");
    idle(1);
    check("R8 literal", product, 16'hA5C3);

    // R5: modulus changes from start to start, same operands
    issue(16'h8142, 16'h3C77, 8'h01, 8'h00, "R5 modulus one");
    issue(16'h8142, 16'h3C77, 8'hF0, 8'h0F, "R5 modulus two");
    issue(16'h8142, 16'h3C77, 8'h2B, 8'h91, "R5 modulus three");
    idle(1);

    // R6: inputs wiggle without start, result must hold
    held = product;
    for (int i = 0; i < 6; i++) begin
      aOp = 16'($urandom); bOp = 16'($urandom);
      modC1 = 8'($urandom); modC0 = 8'($urandom);
      @(negedge clk);
      check("R6 product held", product, held);
      check("R6 no done", 16'(done), 16'h0);
    end

    // R3 and R10: gap-free random bursts, fresh modulus from two roots
    for (int burst = 0; burst < 4; burst++) begin
      for (int i = 0; i < 40; i++) begin
        r1 = 8'($urandom);
        do r2 = 8'($urandom); while (r2 == r1);
        issue(16'($urandom), 16'($urandom), r1 ^ r2, fieldMul(r1, r2),
              "R3 R10 random back-to-back");
      end
      idle(1 + burst);
    end

    idle(3);
    check("R10 all results delivered", 16'(expQ.size()), 16'h0);
    finished = 1'b1;
    report();
  end

endmodule